// File: doc/BRIEF.md
# Three-Level-Leg Dual-Output PWM Gate Generator

This block produces the gate commands for three phase legs of an inverter in which every leg stacks three switches (top, middle, bottom) and feeds two separate three-phase outputs. The upper output node sits between the top and middle switch, and the lower output node sits between the middle and bottom switch. For each phase the block receives two signed references, one for the upper output and one for the lower output. Both references are compared with one triangular carrier. The carrier is generated inside the block and is shared by all six references.

Each comparison acts like one leg of an ordinary two-level bridge. The middle switch is the XOR of the lower switch of the upper virtual bridge and the upper switch of the lower virtual bridge. Because of this, a leg can never turn all three switches on.

A leg goes to the all-off state only when its lower reference is above its upper reference. The block catches this case at the moment the references are sampled. It raises a sticky error flag for that phase. When safe mode is enabled, the block holds that leg in the state in which the upper output is high and the lower output is low.

References are taken in only at the carrier turnarounds. This keeps each comparison stable for a whole half period.

Top module: `nsi_gate_gen`

## Requirements
- R1: The carrier `carrier` counts up by one per clock from 0 to `half_period`, then down by one per clock to 0, and repeats. `car_dir` is 1 while counting up. A new `half_period` takes effect at once. A count above it turns down on the next clock.
- R2: `half_strobe` is 1 exactly in the cycle in which the carrier turns around. That is the cycle with `car_dir`=1 and `carrier` ≥ `half_period`, or the cycle with `car_dir`=0 and `carrier`=0.
- R3: References are two's complement. Each is compared as its value plus 2^(W-1) (offset binary). Phase p uses bits [p*W +: W] of `ref_hi` and `ref_lo`. A reference is captured only on the clock edge at which `half_strobe` is 1. Changes at any other time have no effect on the gates.
- R4: `gate_top[p]` is 1 one clock after a cycle in which the held upper reference of phase p (offset) is greater than `carrier`.
- R5: `gate_bot[p]` is 1 one clock after a cycle in which the held lower reference (offset) is not greater than `carrier`.
- R6: `gate_mid[p]` is the XOR of the inverted upper comparison and the lower comparison. With (top, mid, bot), this gives (1,1,0) when both comparisons are high, (1,0,1) when only the upper one is high, and (0,1,1) when neither is high.
- R7: No leg ever outputs (1,1,1).
- R8: `err_flag[p]` is set by a sampling edge at which the lower reference of phase p is greater than the upper one (signed). It stays set until a clock edge with `err_clr`=1 and no new violation. A new violation wins over a clear.
- R9: One clock after a cycle with `safe_en`=1 and `err_flag[p]`=1, leg p outputs (1,0,1).
- R10: During reset the carrier is 0 and counting up. All gates are 0 and all error flags are 0. The held references are 0.
- R11: If every held reference (offset) lies in 1..`half_period`, all legs output (1,1,0) after a carrier-valley cycle and (0,1,1) after a carrier-peak cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_period | input | W | Carrier peak value |
| ref_hi | input | 3*W | Upper-output references, one signed W-bit field per phase |
| ref_lo | input | 3*W | Lower-output references, one signed W-bit field per phase |
| safe_en | input | 1 | Force flagged legs to (1,0,1) |
| err_clr | input | 1 | Clear the sticky error flags |
| carrier | output | W | Carrier count |
| car_dir | output | 1 | Carrier direction, 1 = up |
| half_strobe | output | 1 | Carrier turnaround cycle |
| gate_top | output | 3 | Top switch per phase |
| gate_mid | output | 3 | Middle switch per phase |
| gate_bot | output | 3 | Bottom switch per phase |
| err_flag | output | 3 | Sticky ordering-error flag per phase |

## Verification
The turnaround property assumes that `half_period` is nonzero. With a zero peak the carrier sits at 0 and its direction flag only toggles. The counting property assumes that `half_period` only changes in ways the count rule of R1 covers. The stimulus keeps the peak at 255, 10, 6 or 30 and changes it only while the carrier is running. The references span the full signed range, including extreme and equal pairs. Ordering violations are driven on one phase at a time, both with and without safe mode. A clear is issued while a violation is still present, so that the set-over-clear rule is exercised.

// File: rtl/nsi_gate_gen.sv
module nsi_gate_gen #(
  parameter int W   = 8,
  parameter int NPH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     half_period,
  input  logic [NPH*W-1:0] ref_hi,
  input  logic [NPH*W-1:0] ref_lo,
  input  logic             safe_en,
  input  logic             err_clr,
  output logic [W-1:0]     carrier,
  output logic             car_dir,
  output logic             half_strobe,
  output logic [NPH-1:0]   gate_top,
  output logic [NPH-1:0]   gate_mid,
  output logic [NPH-1:0]   gate_bot,
  output logic [NPH-1:0]   err_flag
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] BIAS = ONE << (W-1);

  logic [W-1:0] cnt;
  logic         up;
  logic         at_peak, at_valley;

  assign at_peak     = up && (cnt >= half_period);
  assign at_valley   = !up && (cnt == '0);
  assign half_strobe = at_peak || at_valley;
  assign carrier     = cnt;
  assign car_dir     = up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (at_peak) begin
      up  <= 1'b0;
      cnt <= (half_period == '0) ? '0 : cnt - ONE;
    end else if (at_valley) begin
      up  <= 1'b1;
      cnt <= (half_period == '0) ? '0 : ONE;
    end else begin
      cnt <= up ? cnt + ONE : cnt - ONE;
    end
  end

  logic [W-1:0]   hu [NPH];
  logic [W-1:0]   lu [NPH];
  logic [NPH-1:0] c_hi, c_lo, viol;

  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      c_hi[p] = hu[p] > cnt;
      c_lo[p] = lu[p] > cnt;
      viol[p] = (ref_lo[p*W +: W] ^ BIAS) > (ref_hi[p*W +: W] ^ BIAS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPH; p++) begin
        hu[p] <= BIAS;
        lu[p] <= BIAS;
      end
      err_flag <= '0;
      gate_top <= '0;
      gate_mid <= '0;
      gate_bot <= '0;
    end else begin
      for (int p = 0; p < NPH; p++) begin
        if (half_strobe) begin
          hu[p] <= ref_hi[p*W +: W] ^ BIAS;
          lu[p] <= ref_lo[p*W +: W] ^ BIAS;
        end
        if (half_strobe && viol[p]) err_flag[p] <= 1'b1;
        else if (err_clr)           err_flag[p] <= 1'b0;
        if (safe_en && err_flag[p]) begin
          gate_top[p] <= 1'b1;
          gate_mid[p] <= 1'b0;
          gate_bot[p] <= 1'b1;
        end else begin
          gate_top[p] <= c_hi[p];
          gate_mid[p] <= !c_hi[p] ^ c_lo[p];
          gate_bot[p] <= !c_lo[p];
        end
      end
    end
  end
endmodule

// File: rtl/nsi_gate_gen_chk.sv
module nsi_gate_gen_chk #(
  parameter int W   = 8,
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [W-1:0]   half_period,
  input logic           safe_en,
  input logic           err_clr,
  input logic [W-1:0]   carrier,
  input logic           car_dir,
  input logic           half_strobe,
  input logic [NPH-1:0] gate_top,
  input logic [NPH-1:0] gate_mid,
  input logic [NPH-1:0] gate_bot,
  input logic [NPH-1:0] err_flag
);
  p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    car_dir && !half_strobe |=> carrier == $past(carrier) + 1'b1);

  p_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_strobe && (half_period != '0) |=> car_dir != $past(car_dir));

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    p_no_all_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_top[p] && gate_mid[p] && gate_bot[p]));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag[p] && !err_clr |=> err_flag[p]);

    p_safe_leg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      safe_en && err_flag[p] |=> gate_top[p] && !gate_mid[p] && gate_bot[p]);
  end
endmodule

bind nsi_gate_gen nsi_gate_gen_chk #(.W(W), .NPH(NPH)) chk_i (
  .clk(clk), .rst_n(rst_n), .half_period(half_period), .safe_en(safe_en),
  .err_clr(err_clr), .carrier(carrier), .car_dir(car_dir),
  .half_strobe(half_strobe), .gate_top(gate_top), .gate_mid(gate_mid),
  .gate_bot(gate_bot), .err_flag(err_flag)
);

// File: tb/nsi_gate_gen_tb_top.sv
module nsi_gate_gen_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] half_period = 8'd255;
  logic signed [W-1:0] in_hi [3];
  logic signed [W-1:0] in_lo [3];
  logic safe_en = 1'b0;
  logic err_clr = 1'b0;
  logic [W-1:0] carrier;
  logic car_dir, half_strobe;
  logic [2:0] gate_top, gate_mid, gate_bot, err_flag;
  logic [3*W-1:0] ref_hi, ref_lo;

  assign ref_hi = {in_hi[2], in_hi[1], in_hi[0]};
  assign ref_lo = {in_lo[2], in_lo[1], in_lo[0]};

  always #2 clk = ~clk;

  nsi_gate_gen #(.W(W), .NPH(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_period(half_period), .ref_hi(ref_hi),
    .ref_lo(ref_lo), .safe_en(safe_en), .err_clr(err_clr), .carrier(carrier),
    .car_dir(car_dir), .half_strobe(half_strobe), .gate_top(gate_top),
    .gate_mid(gate_mid), .gate_bot(gate_bot), .err_flag(err_flag)
  );

  typedef struct packed {
    logic [8:0] g;
    logic [2:0] forced;
    logic [1:0] r11;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int r11_seen = 0;
  bit mon_en = 0;
  bit done = 0;

  int m_cnt;
  bit m_dir;
  int m_hu [3];
  int m_lu [3];
  bit m_err [3];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_expect();
    exp_t e;
    bit all_lo, all_hi;
    e = '0;
    all_lo = 1;
    all_hi = 1;
    for (int p = 0; p < 3; p++) begin
      bit h, l;
      h = m_hu[p] > m_cnt;
      l = m_lu[p] > m_cnt;
      if (safe_en && m_err[p]) begin
        e.g[3*p +: 3] = 3'b101;
        e.forced[p] = 1'b1;
      end else begin
        e.g[3*p +: 3] = {h, !h ^ l, !l};
      end
      if (m_hu[p] < 1 || m_hu[p] > int'(half_period) ||
          m_lu[p] < 1 || m_lu[p] > int'(half_period)) begin
        all_lo = 0;
        all_hi = 0;
      end
    end
    if (e.forced == 3'b000 && all_lo && m_cnt == 0) e.r11 = 2'd1;
    if (e.forced == 3'b000 && all_hi && m_cnt == int'(half_period)) e.r11 = 2'd2;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      exp_t e;
      bit strobe;
      strobe = (m_dir && m_cnt >= int'(half_period)) || (!m_dir && m_cnt == 0);
      chk(int'(carrier) == m_cnt, "R1 carrier", int'(carrier), m_cnt);
      chk(car_dir == m_dir, "R1 direction", int'(car_dir), int'(m_dir));
      chk(half_strobe == strobe, "R2 strobe", int'(half_strobe), int'(strobe));
      e = q.pop_front();
      for (int p = 0; p < 3; p++) begin
        chk(err_flag[p] == m_err[p], "R8 error flag", int'(err_flag[p]), int'(m_err[p]));
        chk(!(gate_top[p] && gate_mid[p] && gate_bot[p]), "R7 all-on leg", 7, 0);
        if (e.forced[p]) begin
          chk({gate_top[p], gate_mid[p], gate_bot[p]} == 3'b101, "R9 safe leg",
              int'({gate_top[p], gate_mid[p], gate_bot[p]}), 5);
        end else begin
          chk(gate_top[p] == e.g[3*p+2], "R4 top (refs per R3)", int'(gate_top[p]), int'(e.g[3*p+2]));
          chk(gate_mid[p] == e.g[3*p+1], "R6 middle", int'(gate_mid[p]), int'(e.g[3*p+1]));
          chk(gate_bot[p] == e.g[3*p], "R5 bottom", int'(gate_bot[p]), int'(e.g[3*p]));
        end
      end
      if (e.r11 != 2'd0) begin
        r11_seen++;
        chk({gate_top, gate_mid, gate_bot} == ((e.r11 == 2'd1) ? 9'b111_111_000 : 9'b000_111_111),
            "R11 null state", int'({gate_top, gate_mid, gate_bot}), int'(e.r11));
      end
      push_expect();
      for (int p = 0; p < 3; p++) begin
        bit v;
        v = strobe && (int'(in_lo[p]) > int'(in_hi[p]));
        if (v) m_err[p] = 1'b1;
        else if (err_clr) m_err[p] = 1'b0;
        if (strobe) begin
          m_hu[p] = int'(in_hi[p]) + 128;
          m_lu[p] = int'(in_lo[p]) + 128;
        end
      end
      if (m_dir && m_cnt >= int'(half_period)) begin
        m_dir = 0;
        m_cnt = (half_period == 0) ? 0 : m_cnt - 1;
      end else if (!m_dir && m_cnt == 0) begin
        m_dir = 1;
        m_cnt = (half_period == 0) ? 0 : 1;
      end else begin
        m_cnt = m_dir ? m_cnt + 1 : m_cnt - 1;
      end
    end
  end

  task automatic drive(input int h0, input int h1, input int h2,
                       input int l0, input int l1, input int l2, input int ncyc);
    @(posedge clk); #1;
    in_hi[0] = W'(h0); in_hi[1] = W'(h1); in_hi[2] = W'(h2);
    in_lo[0] = W'(l0); in_lo[1] = W'(l1); in_lo[2] = W'(l2);
    repeat (ncyc) @(posedge clk);
  endtask

  task automatic pulse_clear();
    @(posedge clk); #1 err_clr = 1'b1;
    @(posedge clk); #1 err_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 3; p++) begin
      in_hi[p] = '0;
      in_lo[p] = '0;
      m_hu[p] = 128;
      m_lu[p] = 128;
      m_err[p] = 0;
    end
    m_cnt = 0;
    m_dir = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(carrier == '0 && car_dir == 1'b1, "R10 reset carrier", int'(carrier), 0);
    chk({gate_top, gate_mid, gate_bot} == '0, "R10 reset gates",
        int'({gate_top, gate_mid, gate_bot}), 0);
    chk(err_flag == '0, "R10 reset flags", int'(err_flag), 0);
    q.push_back('0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_en = 1;

    drive(60, -30, -30, 20, -70, -70, 600);
    drive(100, 0, -100, 50, -20, -110, 700);
    drive(127, 127, 127, -128, -128, 127, 600);

    drive(10, 0, 0, 40, 0, 0, 600);
    pulse_clear();
    repeat (300) @(posedge clk);
    drive(10, 0, 0, -10, 0, 0, 600);
    pulse_clear();
    repeat (300) @(posedge clk);

    @(posedge clk); #1 safe_en = 1'b1;
    drive(0, 50, 0, 0, 90, 0, 700);
    drive(0, 50, 0, 0, 20, 0, 600);
    pulse_clear();
    repeat (300) @(posedge clk);
    @(posedge clk); #1 safe_en = 1'b0;

    @(posedge clk); #1 half_period = 8'd10;
    drive(-123, -120, -125, -126, -127, -125, 200);
    @(posedge clk); #1 half_period = 8'd6;
    drive(-123, -124, -125, -126, -127, -125, 200);
    @(posedge clk); #1 half_period = 8'd30;
    drive(-110, -100, -120, -115, -127, -121, 300);

    @(negedge clk);
    mon_en = 0;
    chk(r11_seen > 0, "R11 null states exercised", r11_seen, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule